// File: doc/BRIEF.md
# Trigger Timing Identifier Generator

This block runs on the bunch-crossing clock and keeps two counters. The first counts bunch crossings inside one machine orbit. The second counts accepted triggers. Each counter is cleared by its own broadcast reset strobe. The inputs are a bunch-crossing reset, an event-counter reset, a level-1 accept strobe and a trigger-type byte.

For every accept, the block presents a record for one clock cycle. The record holds the current crossing number, the current event number and the trigger type seen with the accept. Downstream checking logic uses the record in two ways: to compare against header identifiers in received data, or to stamp data that it injects itself. Between accepts the record fields keep their last values.

Counter widths, the last crossing number of an orbit and the trigger-type width are parameters. A generate choice picks a free-running wrap when the orbit length fills the counter range, and an explicit compare-and-clear when it does not.

Top module: `ttid_gen`

## Requirements
- R1: While `rst` is high, `id_valid` is 0 and `id_bcid`, `id_evid` and `id_ttype` are 0. An accept in the first cycle after `rst` falls reports crossing 0 and event 0.
- R2: Without a crossing reset, the crossing number advances by exactly one every clock cycle.
- R3: The crossing number wraps from `BC_LAST` (default 3563) to 0 when no crossing reset arrives.
- R4: A crossing reset makes the crossing number 0 in the following cycle.
- R5: When a crossing reset and an accept arrive in the same cycle, the record carries the crossing number from before the reset.
- R6: The event number rises by one after each accept is reported. The first accept after an event-counter reset reports 0.
- R7: When an event-counter reset and an accept arrive in the same cycle, the record carries the event number from before the reset, and the next accept reports 0.
- R8: `id_ttype` takes the `trig_type` value present in the accept cycle. `trig_type` in other cycles has no effect on the record.
- R9: `id_valid` is high for exactly one cycle, in the cycle after each accept. Accepts on consecutive cycles give consecutive valid cycles.
- R10: In cycles with no accept, `id_bcid`, `id_evid` and `id_ttype` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| bc_reset | input | 1 | Crossing-counter reset strobe |
| ev_reset | input | 1 | Event-counter reset strobe |
| l1_accept | input | 1 | Level-1 accept strobe |
| trig_type | input | TT_W (8) | Trigger type, sampled with the accept |
| id_valid | output | 1 | Record strobe, one cycle per accept |
| id_bcid | output | BC_W (12) | Crossing number of the accepted cycle |
| id_evid | output | EV_W (24) | Event number of the accepted trigger |
| id_ttype | output | TT_W (8) | Trigger type of the accepted trigger |

## Verification
Every record appears exactly one clock edge after the cycle that carries its accept. The crossing number in that record is the counter value during the accept cycle, so it equals the number of cycles since the last crossing reset minus one.

The bench drives each stimulus row just after a rising edge and samples the outputs 2 ns after the next rising edge. Each row's expected record therefore belongs to that row's own inputs. Expected crossing numbers follow from counting rows since the last crossing reset. The wrap test places an accept exactly 3563 idle rows after a reset, and then one row later.

// File: rtl/ttid_pkg.sv
package ttid_pkg;

   localparam int unsigned DEF_BC_W    = 12;
   localparam int unsigned DEF_BC_LAST = 3563;
   localparam int unsigned DEF_EV_W    = 24;
   localparam int unsigned DEF_TT_W    = 8;

   // True when the orbit length exactly fills a W-bit counter
   function automatic bit fills_range(int unsigned last, int unsigned w);
      longint unsigned span;
      span = longint'(last) + 64'd1;
      return span == (64'd1 << w);
   endfunction

endpackage

// File: rtl/ttid_bc_counter.sv
module ttid_bc_counter #(
   parameter int unsigned W    = ttid_pkg::DEF_BC_W,
   parameter int unsigned LAST = ttid_pkg::DEF_BC_LAST
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] LAST_V = W'(LAST);
   localparam bit           FREE   = ttid_pkg::fills_range(LAST, W);

   logic [W-1:0] nxt;

   generate
      if (FREE) begin : g_free_wrap
         always_comb nxt = count + 1'b1;
      end else begin : g_cmp_wrap
         always_comb nxt = (count == LAST_V) ? '0 : count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) count <= '0;
      else            count <= nxt;
   end

   a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
      clr |=> count == '0);

   a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
      (!clr && count != LAST_V) |=> count == $past(count) + 1'b1);

   a_r3_orbit_wrap: assert property (@(posedge clk) disable iff (rst)
      (!clr && count == LAST_V) |=> count == '0);

endmodule

// File: rtl/ttid_ev_counter.sv
module ttid_ev_counter #(
   parameter int unsigned W = ttid_pkg::DEF_EV_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         bump,
   output logic [W-1:0] count
);

   always_ff @(posedge clk) begin
      if (rst || clr)  count <= '0;
      else if (bump)   count <= count + 1'b1;
   end

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
      clr |=> count == '0);

   a_r6_bump_once: assert property (@(posedge clk) disable iff (rst)
      (bump && !clr) |=> count == $past(count) + 1'b1);

   a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!bump && !clr) |=> $stable(count));

endmodule

// File: rtl/ttid_record_reg.sv
module ttid_record_reg #(
   parameter int unsigned BC_W = ttid_pkg::DEF_BC_W,
   parameter int unsigned EV_W = ttid_pkg::DEF_EV_W,
   parameter int unsigned TT_W = ttid_pkg::DEF_TT_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic [BC_W-1:0] bc_in,
   input  logic [EV_W-1:0] ev_in,
   input  logic [TT_W-1:0] tt_in,
   output logic            rec_valid,
   output logic [BC_W-1:0] rec_bc,
   output logic [EV_W-1:0] rec_ev,
   output logic [TT_W-1:0] rec_tt
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rec_valid <= 1'b0;
         rec_bc    <= '0;
         rec_ev    <= '0;
         rec_tt    <= '0;
      end else begin
         rec_valid <= take;
         if (take) begin
            rec_bc <= bc_in;
            rec_ev <= ev_in;
            rec_tt <= tt_in;
         end
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      take |=> rec_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !take |=> !rec_valid);

   a_r8_type_capture: assert property (@(posedge clk) disable iff (rst)
      take |=> rec_tt == $past(tt_in));

   a_r10_fields_hold: assert property (@(posedge clk) disable iff (rst)
      !take |=> ($stable(rec_bc) && $stable(rec_ev) && $stable(rec_tt)));

endmodule

// File: rtl/ttid_gen.sv
module ttid_gen #(
   parameter int unsigned BC_W    = ttid_pkg::DEF_BC_W,
   parameter int unsigned BC_LAST = ttid_pkg::DEF_BC_LAST,
   parameter int unsigned EV_W    = ttid_pkg::DEF_EV_W,
   parameter int unsigned TT_W    = ttid_pkg::DEF_TT_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bc_reset,
   input  logic            ev_reset,
   input  logic            l1_accept,
   input  logic [TT_W-1:0] trig_type,
   output logic            id_valid,
   output logic [BC_W-1:0] id_bcid,
   output logic [EV_W-1:0] id_evid,
   output logic [TT_W-1:0] id_ttype
);

   initial begin
      assert (BC_W >= 1 && BC_W <= 32) else $error("BC_W out of range");
      assert (EV_W >= 1 && EV_W <= 32) else $error("EV_W out of range");
      assert (TT_W >= 1) else $error("TT_W must be positive");
      assert (longint'(BC_LAST) < (64'd1 << BC_W))
         else $error("BC_LAST does not fit in BC_W bits");
   end

   logic [BC_W-1:0] bc_q;
   logic [EV_W-1:0] ev_q;

   ttid_bc_counter #(.W(BC_W), .LAST(BC_LAST)) u_bc (
      .clk   (clk),
      .rst   (rst),
      .clr   (bc_reset),
      .count (bc_q)
   );

   ttid_ev_counter #(.W(EV_W)) u_ev (
      .clk   (clk),
      .rst   (rst),
      .clr   (ev_reset),
      .bump  (l1_accept),
      .count (ev_q)
   );

   ttid_record_reg #(.BC_W(BC_W), .EV_W(EV_W), .TT_W(TT_W)) u_rec (
      .clk       (clk),
      .rst       (rst),
      .take      (l1_accept),
      .bc_in     (bc_q),
      .ev_in     (ev_q),
      .tt_in     (trig_type),
      .rec_valid (id_valid),
      .rec_bc    (id_bcid),
      .rec_ev    (id_evid),
      .rec_tt    (id_ttype)
   );

   a_r5_bcid_pre_reset: assert property (@(posedge clk) disable iff (rst)
      (l1_accept && bc_reset) |=> (id_bcid == $past(bc_q) && bc_q == '0));

   a_r7_evid_pre_reset: assert property (@(posedge clk) disable iff (rst)
      (l1_accept && ev_reset) |=> (id_evid == $past(ev_q) && ev_q == '0));

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      $past(rst) |-> (!id_valid && id_bcid == '0 && id_evid == '0));

endmodule

// File: tb/ttid_gen_tb_top.sv
module ttid_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bcr = 1'b0;
   logic        ecr = 1'b0;
   logic        acc = 1'b0;
   logic [7:0]  tt  = 8'h00;
   logic        v;
   logic [11:0] bcid;
   logic [23:0] evid;
   logic [7:0]  ttyp;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ttid_gen dut_i (
      .clk       (clk),
      .rst       (rst),
      .bc_reset  (bcr),
      .ev_reset  (ecr),
      .l1_accept (acc),
      .trig_type (tt),
      .id_valid  (v),
      .id_bcid   (bcid),
      .id_evid   (evid),
      .id_ttype  (ttyp)
   );

   // {bcr, ecr, acc, tt[7:0], exp_v, exp_bcid[11:0], exp_evid[23:0], exp_tt[7:0]}
   localparam logic [55:0] VEC [12] = '{
      {1'b1,1'b1,1'b0,8'h99, 1'b0,12'd0,24'd0,8'h21},
      {1'b0,1'b0,1'b1,8'h11, 1'b1,12'd0,24'd0,8'h11},
      {1'b0,1'b0,1'b0,8'h99, 1'b0,12'd0,24'd0,8'h11},
      {1'b0,1'b0,1'b1,8'hA5, 1'b1,12'd2,24'd1,8'hA5},
      {1'b0,1'b0,1'b1,8'h3C, 1'b1,12'd3,24'd2,8'h3C},
      {1'b1,1'b0,1'b1,8'h7E, 1'b1,12'd4,24'd3,8'h7E},  // R5 same-cycle crossing reset
      {1'b0,1'b0,1'b1,8'h01, 1'b1,12'd0,24'd4,8'h01},
      {1'b0,1'b1,1'b1,8'hFF, 1'b1,12'd1,24'd5,8'hFF},  // R7 same-cycle event reset
      {1'b0,1'b0,1'b1,8'h00, 1'b1,12'd2,24'd0,8'h00},
      {1'b0,1'b1,1'b0,8'h99, 1'b0,12'd2,24'd0,8'h00},
      {1'b0,1'b0,1'b1,8'h42, 1'b1,12'd4,24'd0,8'h42},
      {1'b0,1'b0,1'b0,8'h99, 1'b0,12'd4,24'd0,8'h42}
   };

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(bit b, bit e, bit a, logic [7:0] t);
      bcr = b; ecr = e; acc = a; tt = t;
      @(posedge clk);
      #2;
   endtask

   task automatic rec(string req, bit xv, int xbc, int xev, int xtt);
      chk(req, "valid", longint'(v), longint'(xv));
      chk(req, "bcid",  longint'(bcid), longint'(xbc));
      chk(req, "evid",  longint'(evid), longint'(xev));
      chk(req, "ttype", longint'(ttyp), longint'(xtt));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: an accept held during reset produces nothing
      rst = 1'b1;
      step(1'b0, 1'b0, 1'b1, 8'h55);
      step(1'b0, 1'b0, 1'b1, 8'h55);
      rec("R1", 1'b0, 0, 0, 0);
      rst = 1'b0;
      step(1'b0, 1'b0, 1'b1, 8'h21);
      rec("R1", 1'b1, 0, 0, 8'h21);

      // table walk: R2 crossing count, R6 event count, R8 type, R9 strobe, R10 hold
      for (int i = 0; i < 12; i++) begin
         logic [55:0] r;
         r = VEC[i];
         step(r[55], r[54], r[53], r[52:45]);
         chk("R9",  "valid", longint'(v),    longint'(r[44]));
         chk("R2",  "bcid",  longint'(bcid), longint'(r[43:32]));
         chk("R6",  "evid",  longint'(evid), longint'(r[31:8]));
         chk("R10", "ttype", longint'(ttyp), longint'(r[7:0]));
      end

      // R3: wrap at the end of the orbit
      step(1'b1, 1'b1, 1'b0, 8'h00);
      for (int k = 0; k < 3563; k++) step(1'b0, 1'b0, 1'b0, 8'h99);
      step(1'b0, 1'b0, 1'b1, 8'h5A);
      rec("R3", 1'b1, 3563, 0, 8'h5A);
      step(1'b0, 1'b0, 1'b1, 8'h5B);
      rec("R3", 1'b1, 0, 1, 8'h5B);

      // R4: crossing reset alone, accept in the next cycle sees 0
      for (int k = 0; k < 7; k++) step(1'b0, 1'b0, 1'b0, 8'h99);
      step(1'b1, 1'b0, 1'b0, 8'h99);
      chk("R4", "valid", longint'(v), 0);
      chk("R8", "ttype ignored", longint'(ttyp), 8'h5B);
      step(1'b0, 1'b0, 1'b1, 8'hC3);
      rec("R4", 1'b1, 0, 2, 8'hC3);

      // R9: strobe drops after a single accept
      step(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R9", "single pulse", longint'(v), 0);

      // R1: reset in mid-run clears record and counters
      rst = 1'b1;
      step(1'b0, 1'b0, 1'b1, 8'h77);
      step(1'b0, 1'b0, 1'b1, 8'h77);
      rec("R1", 1'b0, 0, 0, 0);
      rst = 1'b0;
      step(1'b0, 1'b0, 1'b1, 8'h33);
      rec("R1", 1'b1, 0, 0, 8'h33);
      step(1'b0, 1'b0, 1'b1, 8'h34);
      rec("R6", 1'b1, 1, 1, 8'h34);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule